// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This unit sits beside the control path of an 8-bit processor core and runs the two memory-heavy parts of exception handling. When the core reports an instruction boundary, the unit looks at the pending requests and the live condition-code mask bits. If a request can be taken, it captures the register file and writes it onto a byte-wide stack, one byte per cycle. It then sets the mask bits and fetches a two-byte handler address from a fixed table near the top of memory. Last, it returns the new register state on a restore bus and pulses done.

When the core reports a return-from-interrupt at a boundary, the same datapath runs the other way. It reads the nine saved bytes back in the reverse of the order they were written, and hands back the whole register file. The program counter is the last value restored. Throughout either sequence the unit holds busy high so that the core stalls. Memory is a single synchronous byte port: read data appears one cycle after the address.

Top module: `irq_seq`

## Requirements
- R1: Requests and the return command are sampled only in a cycle where `insn_boundary` is high and `busy` is low; requests raised while `insn_boundary` is low start nothing.
- R2: Entry performs nine consecutive write cycles, starting the cycle after acceptance. The addresses are SP, SP-1, … SP-8. The bytes written are, in this order: PC[7:0], PC[15:8], IY[7:0], IY[15:8], IX[7:0], IX[15:8], A, B, CCR.
- R3: The CCR byte written to the stack is the value captured at acceptance. After entry, `out_ccr` has bit 4 (the maskable-interrupt mask) set, `out_sp` is SP-9, and A, B, IX and IY are returned unchanged.
- R4: Bit 6 of `out_ccr` (the non-maskable mask) is set after entry when the high-priority non-maskable request (`req_xirq`) was the one taken. Otherwise bit 6 keeps its captured value.
- R5: Each handler address is read big-endian from a fixed location, with the high byte at the even address. The locations are $FFF4 for `req_xirq`, $FFF6 for `req_swi`, $FFF2 for `req_irq`, and $FFEC-2k for timer request k. `out_pc` is {mem[v], mem[v+1]}.
- R6: `req_irq` and every timer request are ignored while CCR bit 4 is set. `req_xirq` is ignored while CCR bit 6 is set. `req_swi` is never masked.
- R7: Among requests that are not masked, the priority is `req_xirq`, then `req_swi`, then `req_irq`, then timer 0, timer 1, and so on.
- R8: Return reads SP+1 … SP+9 with no write cycles. The bytes go to CCR, B, A, IX[15:8], IX[7:0], IY[15:8], IY[7:0], PC[15:8], PC[7:0], and `out_sp` becomes SP+9. A return command at a boundary wins over any pending request.
- R9: `busy` is high from the cycle after acceptance until `done` rises. `done` is a one-cycle pulse with `busy` low. It appears 12 cycles after an accepted entry and 10 cycles after an accepted return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_boundary | input | 1 | Core has completed the current instruction |
| rti_req | input | 1 | Current instruction is a return-from-interrupt |
| req_xirq | input | 1 | Non-maskable-by-I interrupt request |
| req_swi | input | 1 | Software interrupt request |
| req_irq | input | 1 | Maskable external interrupt request |
| req_tmr | input | N_TMR | Maskable timer interrupt requests |
| in_pc | input | 16 | Program counter snapshot |
| in_iy | input | 16 | IY snapshot |
| in_ix | input | 16 | IX snapshot |
| in_acca | input | 8 | Accumulator A snapshot |
| in_accb | input | 8 | Accumulator B snapshot |
| in_ccr | input | 8 | Live condition-code register |
| in_sp | input | 16 | Stack pointer snapshot |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after address |
| busy | output | 1 | Core stall |
| done | output | 1 | Restore bus valid pulse |
| out_pc | output | 16 | Restored or vectored program counter |
| out_iy | output | 16 | Restored IY |
| out_ix | output | 16 | Restored IX |
| out_acca | output | 8 | Restored accumulator A |
| out_accb | output | 8 | Restored accumulator B |
| out_ccr | output | 8 | Restored or masked CCR |
| out_sp | output | 16 | Updated stack pointer |

## Verification
The assertions rely on the memory returning read data exactly one cycle after the address it was given. They also rely on the core pulsing the boundary strobe only while the unit is idle, and on no stack sequence wrapping past either end of the address space. The bench meets these conditions as follows. Its memory model has registered reads. It raises `insn_boundary` for a single cycle and only after `done`. Every stack pointer it uses sits well inside the low page, so neither SP-8 nor SP+9 crosses a page edge.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int ADDR_W      = 16;
  localparam int CCR_I_BIT   = 4;
  localparam int CCR_X_BIT   = 6;
  localparam int STACK_BYTES = 9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUSH,
    ST_READ
  } seq_st_t;

  typedef struct packed {
    logic [15:0] pc;
    logic [15:0] iy;
    logic [15:0] ix;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [7:0]  ccr;
  } ctx_t;

  // Stack slot index: 0 is written first (highest address).
  function automatic logic [7:0] get_byte(ctx_t c, logic [3:0] idx);
    case (idx)
      4'd0:    return c.pc[7:0];
      4'd1:    return c.pc[15:8];
      4'd2:    return c.iy[7:0];
      4'd3:    return c.iy[15:8];
      4'd4:    return c.ix[7:0];
      4'd5:    return c.ix[15:8];
      4'd6:    return c.a;
      4'd7:    return c.b;
      default: return c.ccr;
    endcase
  endfunction

  function automatic ctx_t put_byte(ctx_t c, logic [3:0] idx, logic [7:0] v);
    ctx_t r;
    r = c;
    case (idx)
      4'd0:    r.pc[7:0]  = v;
      4'd1:    r.pc[15:8] = v;
      4'd2:    r.iy[7:0]  = v;
      4'd3:    r.iy[15:8] = v;
      4'd4:    r.ix[7:0]  = v;
      4'd5:    r.ix[15:8] = v;
      4'd6:    r.a        = v;
      4'd7:    r.b        = v;
      default: r.ccr      = v;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/irq_arb.sv
module irq_arb
  import irq_seq_pkg::*;
#(
  parameter int               N_TMR    = 3,
  parameter logic [ADDR_W-1:0] VEC_XIRQ = 16'hFFF4,
  parameter logic [ADDR_W-1:0] VEC_SWI  = 16'hFFF6,
  parameter logic [ADDR_W-1:0] VEC_IRQ  = 16'hFFF2,
  parameter logic [ADDR_W-1:0] VEC_TMR0 = 16'hFFEC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_xirq,
  input  logic              req_swi,
  input  logic              req_irq,
  input  logic [N_TMR-1:0]  req_tmr,
  input  logic              mask_i,
  input  logic              mask_x,
  output logic              take,
  output logic              is_xirq,
  output logic [ADDR_W-1:0] vec
);

  logic [ADDR_W-1:0] tvec [N_TMR];

  for (genvar k = 0; k < N_TMR; k++) begin : g_tvec
    assign tvec[k] = VEC_TMR0 - ADDR_W'(2 * k);
  end

  // Later assignments override earlier ones: lowest priority first.
  always_comb begin
    take    = 1'b0;
    is_xirq = 1'b0;
    vec     = '0;
    for (int k = N_TMR - 1; k >= 0; k--) begin
      if (req_tmr[k] && !mask_i) begin
        take = 1'b1;
        vec  = tvec[k];
      end
    end
    if (req_irq && !mask_i) begin
      take = 1'b1;
      vec  = VEC_IRQ;
    end
    if (req_swi) begin
      take = 1'b1;
      vec  = VEC_SWI;
    end
    if (req_xirq && !mask_x) begin
      take    = 1'b1;
      is_xirq = 1'b1;
      vec     = VEC_XIRQ;
    end
  end

  AST_MASKED_ONLY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (take && mask_i) |-> (vec == VEC_XIRQ || vec == VEC_SWI)); // R6

  AST_XIRQ_FIRST: assert property (@(posedge clk) disable iff (rst)
    (req_xirq && !mask_x) |-> (is_xirq && vec == VEC_XIRQ)); // R7

  AST_SWI_NEVER_MASKED: assert property (@(posedge clk) disable iff (rst)
    req_swi |-> take); // R6

endmodule

// File: rtl/irq_seq_ctl.sv
module irq_seq_ctl
  import irq_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary,
  input  logic              rti,
  input  logic              take,
  input  logic              is_xirq,
  input  logic [ADDR_W-1:0] vec,
  input  ctx_t              snap,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              done,
  output ctx_t              out_ctx,
  output logic [ADDR_W-1:0] out_sp
);

  localparam logic [3:0] LAST_IDX = 4'(STACK_BYTES - 1);
  localparam logic [3:0] N_POP    = 4'(STACK_BYTES);
  localparam logic [3:0] N_VEC    = 4'd2;

  seq_st_t           st;
  logic [3:0]        cnt;
  logic [3:0]        rd_slot;
  logic              rd_vld;
  logic              pop_mode;
  logic              set_x;
  ctx_t              ctx;
  logic [ADDR_W-1:0] sp_w;
  logic [ADDR_W-1:0] rd_base;

  logic [3:0] n_rd;
  logic [3:0] cap_idx;
  ctx_t       ctx_nx;

  always_comb begin
    n_rd    = pop_mode ? N_POP : N_VEC;
    cap_idx = pop_mode ? (LAST_IDX - rd_slot) : (4'd1 - rd_slot);
    ctx_nx  = rd_vld ? put_byte(ctx, cap_idx, mem_rdata) : ctx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      rd_slot   <= '0;
      rd_vld    <= 1'b0;
      pop_mode  <= 1'b0;
      set_x     <= 1'b0;
      ctx       <= '0;
      sp_w      <= '0;
      rd_base   <= '0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      out_ctx   <= '0;
      out_sp    <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (boundary && rti) begin
            st       <= ST_READ;
            busy     <= 1'b1;
            pop_mode <= 1'b1;
            cnt      <= '0;
            rd_vld   <= 1'b0;
            ctx      <= snap;
            sp_w     <= sp_in;
            mem_addr <= sp_in + ADDR_W'(1);
          end else if (boundary && take) begin
            st        <= ST_PUSH;
            busy      <= 1'b1;
            pop_mode  <= 1'b0;
            set_x     <= is_xirq;
            cnt       <= '0;
            ctx       <= snap;
            sp_w      <= sp_in;
            rd_base   <= vec;
            mem_addr  <= sp_in;
            mem_we    <= 1'b1;
            mem_wdata <= get_byte(snap, 4'd0);
          end
        end
        ST_PUSH: begin
          if (cnt != LAST_IDX) begin
            cnt       <= cnt + 4'd1;
            mem_addr  <= mem_addr - ADDR_W'(1);
            mem_wdata <= get_byte(ctx, cnt + 4'd1);
          end else begin
            // CCR byte has gone out: only now raise the mask bits.
            ctx.ccr[CCR_I_BIT] <= 1'b1;
            if (set_x) ctx.ccr[CCR_X_BIT] <= 1'b1;
            mem_we   <= 1'b0;
            st       <= ST_READ;
            cnt      <= '0;
            rd_vld   <= 1'b0;
            mem_addr <= rd_base;
          end
        end
        ST_READ: begin
          rd_vld  <= (cnt < n_rd);
          rd_slot <= cnt;
          if (cnt < n_rd) cnt <= cnt + 4'd1;
          if ((cnt + 4'd1) < n_rd) mem_addr <= mem_addr + ADDR_W'(1);
          ctx <= ctx_nx;
          if (rd_vld && rd_slot == n_rd - 4'd1) begin
            st      <= ST_IDLE;
            busy    <= 1'b0;
            done    <= 1'b1;
            rd_vld  <= 1'b0;
            out_ctx <= ctx_nx;
            out_sp  <= pop_mode ? sp_w + ADDR_W'(STACK_BYTES)
                                : sp_w - ADDR_W'(STACK_BYTES);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(boundary)); // R1

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy); // R2

  AST_PUSH_DESCENDS: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - ADDR_W'(1))); // R2

  AST_ENTRY_MASKED: assert property (@(posedge clk) disable iff (rst)
    (done && !pop_mode) |-> out_ctx.ccr[CCR_I_BIT]); // R3

  AST_RETURN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (busy && pop_mode) |-> !mem_we); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9

endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int          N_TMR    = 3,
  parameter logic [15:0] VEC_XIRQ = 16'hFFF4,
  parameter logic [15:0] VEC_SWI  = 16'hFFF6,
  parameter logic [15:0] VEC_IRQ  = 16'hFFF2,
  parameter logic [15:0] VEC_TMR0 = 16'hFFEC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insn_boundary,
  input  logic             rti_req,
  input  logic             req_xirq,
  input  logic             req_swi,
  input  logic             req_irq,
  input  logic [N_TMR-1:0] req_tmr,
  input  logic [15:0]      in_pc,
  input  logic [15:0]      in_iy,
  input  logic [15:0]      in_ix,
  input  logic [7:0]       in_acca,
  input  logic [7:0]       in_accb,
  input  logic [7:0]       in_ccr,
  input  logic [15:0]      in_sp,
  output logic [15:0]      mem_addr,
  output logic             mem_we,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  output logic             busy,
  output logic             done,
  output logic [15:0]      out_pc,
  output logic [15:0]      out_iy,
  output logic [15:0]      out_ix,
  output logic [7:0]       out_acca,
  output logic [7:0]       out_accb,
  output logic [7:0]       out_ccr,
  output logic [15:0]      out_sp
);

  logic        take;
  logic        is_xirq;
  logic [15:0] vec;
  ctx_t        snap;
  ctx_t        res;

  assign snap = '{pc: in_pc, iy: in_iy, ix: in_ix, a: in_acca, b: in_accb, ccr: in_ccr};

  irq_arb #(
    .N_TMR   (N_TMR),
    .VEC_XIRQ(VEC_XIRQ),
    .VEC_SWI (VEC_SWI),
    .VEC_IRQ (VEC_IRQ),
    .VEC_TMR0(VEC_TMR0)
  ) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req_xirq(req_xirq),
    .req_swi (req_swi),
    .req_irq (req_irq),
    .req_tmr (req_tmr),
    .mask_i  (in_ccr[CCR_I_BIT]),
    .mask_x  (in_ccr[CCR_X_BIT]),
    .take    (take),
    .is_xirq (is_xirq),
    .vec     (vec)
  );

  irq_seq_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .boundary (insn_boundary),
    .rti      (rti_req),
    .take     (take),
    .is_xirq  (is_xirq),
    .vec      (vec),
    .snap     (snap),
    .sp_in    (in_sp),
    .mem_rdata(mem_rdata),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata),
    .busy     (busy),
    .done     (done),
    .out_ctx  (res),
    .out_sp   (out_sp)
  );

  assign out_pc   = res.pc;
  assign out_iy   = res.iy;
  assign out_ix   = res.ix;
  assign out_acca = res.a;
  assign out_accb = res.b;
  assign out_ccr  = res.ccr;

endmodule

// File: tb/sim_irq_seq.sv
module sim_irq_seq;

  localparam int CLK_P = 10;
  localparam int NT    = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          insn_boundary, rti_req, req_xirq, req_swi, req_irq;
  logic [NT-1:0] req_tmr;
  logic [15:0]   in_pc, in_iy, in_ix, in_sp;
  logic [7:0]    in_acca, in_accb, in_ccr;
  logic [15:0]   mem_addr;
  logic          mem_we;
  logic [7:0]    mem_wdata, mem_rdata;
  logic          busy, done;
  logic [15:0]   out_pc, out_iy, out_ix, out_sp;
  logic [7:0]    out_acca, out_accb, out_ccr;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] mem [512];

  always #(CLK_P / 2) clk = ~clk;

  irq_seq #(.N_TMR(NT)) u0 (
    .clk(clk), .rst(rst), .insn_boundary(insn_boundary), .rti_req(rti_req),
    .req_xirq(req_xirq), .req_swi(req_swi), .req_irq(req_irq), .req_tmr(req_tmr),
    .in_pc(in_pc), .in_iy(in_iy), .in_ix(in_ix), .in_acca(in_acca),
    .in_accb(in_accb), .in_ccr(in_ccr), .in_sp(in_sp),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .out_pc(out_pc), .out_iy(out_iy), .out_ix(out_ix),
    .out_acca(out_acca), .out_accb(out_accb), .out_ccr(out_ccr), .out_sp(out_sp)
  );

  function automatic int midx(logic [15:0] a);
    return int'({a[15], a[7:0]});
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem[midx(mem_addr)] <= mem_wdata;
    mem_rdata <= mem[midx(mem_addr)];
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  // Vector contents: high byte = low address byte xor 5A, low byte = low address byte.
  function automatic logic [15:0] vec_pc(logic [15:0] v);
    return {v[7:0] ^ 8'h5A, v[7:0]};
  endfunction

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 40) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_case(int c);
    logic [15:0] sp, pc, iy, ix, ev;
    logic [7:0]  a, b, ccr, eccr;
    logic [7:0]  st_b [9];
    bit          mi, mx, tk, xsel;
    int          n;
    mi  = c[6];
    mx  = c[7];
    sp  = 16'h0020 + 16'((c % 16) * 13);
    pc  = 16'h4000 + 16'(c * 257);
    iy  = 16'h9100 ^ 16'(c * 3 + 1);
    ix  = 16'h2300 + 16'(c * 5 + 2);
    a   = 8'(c * 7 + 3);
    b   = 8'(c * 11 + 5);
    ccr = (8'(c * 37) & 8'hAF) | {1'b0, mx, 1'b0, mi, 4'b0};
    // Expected winner by priority and mask (R6, R7).
    tk = 1'b1; xsel = 1'b0; ev = 16'h0;
    if (c[5] && !mx) begin ev = 16'hFFF4; xsel = 1'b1; end
    else if (c[4]) ev = 16'hFFF6;
    else if (c[3] && !mi) ev = 16'hFFF2;
    else if (c[0] && !mi) ev = 16'hFFEC;
    else if (c[1] && !mi) ev = 16'hFFEA;
    else if (c[2] && !mi) ev = 16'hFFE8;
    else tk = 1'b0;

    @(negedge clk);
    req_tmr = c[2:0]; req_irq = c[3]; req_swi = c[4]; req_xirq = c[5];
    in_pc = pc; in_iy = iy; in_ix = ix; in_acca = a; in_accb = b;
    in_ccr = ccr; in_sp = sp; rti_req = 1'b0; insn_boundary = 1'b1;
    @(posedge clk);
    @(negedge clk);
    insn_boundary = 1'b0;
    chk($sformatf("R6 R7 busy case %0d", c), {31'b0, busy}, {31'b0, tk});
    if (!tk) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk($sformatf("R6 masked stays idle case %0d", c), {30'b0, busy, done}, 32'h0);
      end
      return;
    end
    wait_done(n);
    chk($sformatf("R9 entry latency case %0d", c), n, 12);
    chk($sformatf("R5 R7 vector pc case %0d", c), {16'h0, out_pc}, {16'h0, vec_pc(ev)});
    eccr = ccr | 8'h10 | (xsel ? 8'h40 : 8'h00);
    chk($sformatf("R3 R4 out_ccr case %0d", c), {24'h0, out_ccr}, {24'h0, eccr});
    chk($sformatf("R3 out_sp case %0d", c), {16'h0, out_sp}, {16'h0, sp - 16'd9});
    chk($sformatf("R3 pass regs case %0d", c), {out_ix, out_iy}, {ix, iy});
    chk($sformatf("R3 pass acc case %0d", c), {16'h0, out_acca, out_accb}, {16'h0, a, b});
    st_b = '{pc[7:0], pc[15:8], iy[7:0], iy[15:8], ix[7:0], ix[15:8], a, b, ccr};
    for (int k = 0; k < 9; k++)
      chk($sformatf("R2 R3 stack byte %0d case %0d", k, c),
          {24'h0, mem[midx(sp - 16'(k))]}, {24'h0, st_b[k]});
    @(posedge clk);
    @(negedge clk);
    chk($sformatf("R9 done pulse case %0d", c), {31'b0, done}, 32'h0);

    // Return, with requests still raised: return must win (R8).
    in_sp = out_sp; in_pc = 16'hDEAD; in_ccr = 8'h00; in_acca = 8'h00;
    rti_req = 1'b1; insn_boundary = 1'b1;
    @(posedge clk);
    @(negedge clk);
    insn_boundary = 1'b0; rti_req = 1'b0;
    chk($sformatf("R9 busy on return case %0d", c), {31'b0, busy}, 32'h1);
    wait_done(n);
    chk($sformatf("R8 R9 return latency case %0d", c), n, 10);
    chk($sformatf("R8 restored pc case %0d", c), {16'h0, out_pc}, {16'h0, pc});
    chk($sformatf("R8 restored index case %0d", c), {out_ix, out_iy}, {ix, iy});
    chk($sformatf("R8 restored acc ccr case %0d", c),
        {8'h0, out_acca, out_accb, out_ccr}, {8'h0, a, b, ccr});
    chk($sformatf("R8 restored sp case %0d", c), {16'h0, out_sp}, {16'h0, sp});
    chk($sformatf("R8 stack untouched case %0d", c),
        {24'h0, mem[midx(sp - 16'd8)]}, {24'h0, ccr});
    req_tmr = '0; req_irq = 1'b0; req_swi = 1'b0; req_xirq = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; insn_boundary = 1'b0; rti_req = 1'b0;
    req_xirq = 1'b0; req_swi = 1'b0; req_irq = 1'b0; req_tmr = '0;
    in_pc = '0; in_iy = '0; in_ix = '0; in_acca = '0; in_accb = '0;
    in_ccr = '0; in_sp = 16'h0080;
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    begin
      logic [15:0] vl [6];
      vl = '{16'hFFF4, 16'hFFF6, 16'hFFF2, 16'hFFEC, 16'hFFEA, 16'hFFE8};
      for (int i = 0; i < 6; i++) begin
        mem[midx(vl[i])]         = vec_pc(vl[i]) >> 8;
        mem[midx(vl[i] + 16'd1)] = 8'(vec_pc(vl[i]));
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset busy/done", {30'b0, busy, done}, 32'h0);
    chk("R2 reset mem_we", {31'b0, mem_we}, 32'h0);

    // R1: requests without a boundary start nothing.
    req_swi = 1'b1; req_xirq = 1'b1; req_irq = 1'b1; req_tmr = '1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1 no boundary no start", {30'b0, busy, mem_we}, 32'h0);
    end
    req_swi = 1'b0; req_xirq = 1'b0; req_irq = 1'b0; req_tmr = '0;

    for (int c = 0; c < 256; c++) run_case(c);

    summary();
    $finish;
  end

endmodule